// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Controller

This block decides when a half-duplex Ethernet MAC may begin sending a frame. It enforces the inter-packet gap by counting bit-time ticks. The gap normally starts when transmit enable rises. After a collision, or while another station holds the carrier, it starts when the carrier drops. The block counts the collisions of the current frame and draws a random backoff wait for each retry. It detects collisions that come too late in a frame, and decides whether a frame that keeps colliding is retried or dropped.

The MAC watches `tx_permit` and raises `tx_en` only while it is high. It loops its own carrier back on `crs`. The block reports each collision outcome as a one-clock strobe: retry, drop after excessive collisions, or late-collision drop. Frame serialization, jam generation and CRC are handled elsewhere.

Top module: `hdx_defer_ctrl`

## Requirements
- R1: While `rst` is high, `tx_permit`, `retry_stb`, `drop_stb` and `late_col_stb` are low. On the first clock after reset with an idle medium, `tx_permit` is high.
- R2: After a frame without a collision, `tx_permit` rises `GAP_BITS` bit ticks after the cycle in which `tx_en` was first seen high, or one cycle after `tx_en` falls if that is later. `tx_permit` stays low while `tx_en` is high.
- R3: The gap timer advances only on clocks with `bit_tick` high. While `bit_tick` is held low, `tx_permit` does not return after a frame.
- R4: While `crs` is high and the block is not transmitting, `tx_permit` is low. The gap restarts when `crs` falls and `tx_permit` returns `GAP_BITS` ticks later.
- R5: After a collision, the gap is measured from the cycle in which `crs`, `tx_en` and `col` are all low, not from the start of the frame.
- R6: A collision with `tx_en` high is collision n of the frame (n counted from 1). On a retry, `retry_stb` pulses and the wait is r slots of `SLOT_BITS` ticks, where r is drawn from 0 to 2^min(n,`EXP_MAX`)-1. The random value comes from a 16-bit LFSR that advances every clock. `tx_permit` returns after the later of the gap and the backoff.
- R7: With `cfg_fast_backoff` high when a collision occurs, the exponent is capped at `EXP_AGGR` (3), so r is at most 7.
- R8: With `cfg_drop_excess` high, collision number `MAX_TRIES` (16) pulses `drop_stb` instead of `retry_stb`. No backoff follows, and the next collision counts as n=1.
- R9: With `cfg_drop_excess` low, collision `MAX_TRIES` is retried and the count wraps, so the following collisions count again from n=1.
- R10: A collision seen once at least `LATE_BITS` ticks have elapsed after the cycle in which `tx_en` was first seen high pulses `late_col_stb`. The frame is dropped with no retry or backoff, and the collision count clears. One tick less is an ordinary collision.
- R11: A frame that ends without a collision clears the collision count.
- R12: At most one of the three strobes is high in a cycle, and each strobe lasts one clock per collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per bit time |
| tx_en | input | 1 | MAC transmit enable |
| crs | input | 1 | Carrier sense (own or remote) |
| col | input | 1 | Collision indication |
| cfg_drop_excess | input | 1 | Drop the frame after `MAX_TRIES` collisions |
| cfg_fast_backoff | input | 1 | Cap the backoff exponent at `EXP_AGGR` |
| tx_permit | output | 1 | MAC may start a frame |
| retry_stb | output | 1 | Collision resolved by retry |
| drop_stb | output | 1 | Frame dropped after excessive collisions |
| late_col_stb | output | 1 | Frame dropped by a late collision |

## Verification
Collision-free frames shorter and longer than the gap show whether the gap is counted from the rise of `tx_en` or from its fall. A remote carrier and a long jam after a collision show that the reference point moves to the carrier's end. Runs of consecutive collisions in normal mode, aggressive mode, and with the drop option on and off separate the exponent cap, the drop decision and count wrapping from count saturation. Each wait is matched against the exact set of cycle counts a legal slot draw allows. Collisions one tick either side of the late threshold, and frames between collision runs, show when the count clears.

// File: rtl/hdx_defer_pkg.sv
`timescale 1ns/1ps
package hdx_defer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_COLWAIT = 2'd2,
    ST_BACKOFF = 2'd3
  } hdx_state_t;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RETRY = 2'd1,
    EV_DROP  = 2'd2,
    EV_LATE  = 2'd3
  } hdx_event_t;
endpackage

// File: rtl/hdx_lfsr.sv
`timescale 1ns/1ps
module hdx_lfsr #(
  parameter int             W     = 16,
  parameter int             OUT_W = 10,
  parameter logic [W-1:0]   TAPS  = 16'hB400,
  parameter logic [W-1:0]   SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] q;

  // Galois form, right shift, advances on every clock
  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  assign rnd = q[OUT_W-1:0];

  assert_lfsr_alive_R6: assert property (@(posedge clk) disable iff (rst) q != '0);
endmodule

// File: rtl/hdx_gap_timer.sv
`timescale 1ns/1ps
module hdx_gap_timer #(
  parameter int GAP_BITS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic restart,
  output logic gap_done
);
  localparam int CW = $clog2(GAP_BITS + 1);
  localparam logic [CW-1:0] GAP_C = CW'(GAP_BITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= GAP_C;
    else if (restart)                cnt <= '0;
    else if (bit_tick && cnt != GAP_C) cnt <= cnt + 1'b1;
  end

  assign gap_done = (cnt == GAP_C);

  assert_gap_saturates_R3: assert property (@(posedge clk) disable iff (rst)
    !bit_tick && !restart |=> $stable(cnt));
endmodule

// File: rtl/hdx_backoff.sv
`timescale 1ns/1ps
module hdx_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int EXP_MAX   = 10,
  parameter int EXP_AGGR  = 3,
  parameter int AW        = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               load,
  input  logic [AW-1:0]      attempt,
  input  logic               aggressive,
  input  logic [EXP_MAX-1:0] rnd,
  input  logic               run,
  output logic               expired
);
  localparam int SW = (SLOT_BITS > 2) ? $clog2(SLOT_BITS) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_BITS - 1);

  logic [EXP_MAX-1:0] mask;
  logic [EXP_MAX-1:0] rem;
  logic [SW-1:0]      sub;
  int unsigned        cap_i;
  int unsigned        k_i;

  always_comb begin
    cap_i = aggressive ? EXP_AGGR : EXP_MAX;
    k_i   = (int'(attempt) > int'(cap_i)) ? cap_i : int'(attempt);
    for (int i = 0; i < EXP_MAX; i++) mask[i] = (i < int'(k_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      sub <= '0;
    end else if (load) begin
      rem <= rnd & mask;
      sub <= '0;
    end else if (run && bit_tick && rem != '0) begin
      if (sub == SLOT_LAST) begin
        sub <= '0;
        rem <= rem - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign expired = (rem == '0);

  assert_first_draw_small_R6: assert property (@(posedge clk) disable iff (rst)
    load && attempt == AW'(1) |=> int'(rem) <= 1);
  assert_fast_cap_R7: assert property (@(posedge clk) disable iff (rst)
    load && aggressive |=> int'(rem) < (1 << EXP_AGGR));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load && !run |=> $stable(rem));
endmodule

// File: rtl/hdx_defer_ctrl.sv
`timescale 1ns/1ps
module hdx_defer_ctrl
  import hdx_defer_pkg::*;
#(
  parameter int           GAP_BITS  = 96,
  parameter int           SLOT_BITS = 512,
  parameter int           LATE_BITS = 512,
  parameter int           MAX_TRIES = 16,
  parameter int           EXP_MAX   = 10,
  parameter int           EXP_AGGR  = 3,
  parameter int           LFSR_W    = 16,
  parameter logic [15:0]  LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic tx_en,
  input  logic crs,
  input  logic col,
  input  logic cfg_drop_excess,
  input  logic cfg_fast_backoff,
  output logic tx_permit,
  output logic retry_stb,
  output logic drop_stb,
  output logic late_col_stb
);
  localparam int AW  = $clog2(MAX_TRIES + 1);
  localparam int TBW = $clog2(LATE_BITS + 1);
  localparam logic [TBW-1:0] LATE_C = TBW'(LATE_BITS);
  localparam logic [AW-1:0]  MAX_C  = AW'(MAX_TRIES);

  hdx_state_t         state, state_nx;
  hdx_event_t         ev;
  logic               tx_en_q;
  logic [AW-1:0]      attempts;
  logic [AW-1:0]      n_next;
  logic [TBW-1:0]     tx_bits;
  logic               bo_armed;
  logic               hit, is_late, excess, medium_busy;
  logic               gap_restart, gap_done, bo_expired;
  logic [EXP_MAX-1:0] rnd;

  hdx_lfsr #(.W(LFSR_W), .OUT_W(EXP_MAX), .SEED(LFSR_SEED[LFSR_W-1:0])) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  assign medium_busy = crs | tx_en | col;
  assign gap_restart = (tx_en && !tx_en_q)
                     || (state == ST_IDLE && crs && !tx_en)
                     || (state == ST_COLWAIT && medium_busy);

  hdx_gap_timer #(.GAP_BITS(GAP_BITS)) u_gap (
    .clk(clk), .rst(rst), .bit_tick(bit_tick),
    .restart(gap_restart), .gap_done(gap_done)
  );

  // collision decision
  always_comb begin
    hit     = (state == ST_TX) && tx_en && col;
    n_next  = attempts + 1'b1;
    is_late = (tx_bits >= LATE_C);
    excess  = (n_next == MAX_C);
    if (!hit)                          ev = EV_NONE;
    else if (is_late)                  ev = EV_LATE;
    else if (excess && cfg_drop_excess) ev = EV_DROP;
    else                               ev = EV_RETRY;
  end

  hdx_backoff #(.SLOT_BITS(SLOT_BITS), .EXP_MAX(EXP_MAX), .EXP_AGGR(EXP_AGGR), .AW(AW)) u_bo (
    .clk(clk), .rst(rst), .bit_tick(bit_tick),
    .load(ev == EV_RETRY), .attempt(n_next), .aggressive(cfg_fast_backoff),
    .rnd(rnd), .run(state == ST_BACKOFF), .expired(bo_expired)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (tx_en) state_nx = ST_TX;
      ST_TX:      if (hit) state_nx = ST_COLWAIT;
                  else if (!tx_en) state_nx = ST_IDLE;
      ST_COLWAIT: if (!medium_busy)
                    state_nx = (bo_armed && !bo_expired) ? ST_BACKOFF : ST_IDLE;
      ST_BACKOFF: if (bo_expired) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      tx_en_q      <= 1'b0;
      attempts     <= '0;
      tx_bits      <= '0;
      bo_armed     <= 1'b0;
      tx_permit    <= 1'b0;
      retry_stb    <= 1'b0;
      drop_stb     <= 1'b0;
      late_col_stb <= 1'b0;
    end else begin
      state   <= state_nx;
      tx_en_q <= tx_en;

      if (state == ST_IDLE)
        tx_bits <= '0;
      else if (state == ST_TX && bit_tick && tx_bits != LATE_C)
        tx_bits <= tx_bits + 1'b1;

      if (hit) begin
        bo_armed <= (ev == EV_RETRY);
        if (ev == EV_RETRY) attempts <= excess ? '0 : n_next;
        else                attempts <= '0;
      end else if (state == ST_TX && !tx_en) begin
        attempts <= '0;
      end

      tx_permit    <= (state == ST_IDLE) && gap_done && !crs && !tx_en;
      retry_stb    <= (ev == EV_RETRY);
      drop_stb     <= (ev == EV_DROP);
      late_col_stb <= (ev == EV_LATE);
    end
  end

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({retry_stb, drop_stb, late_col_stb}));
  assert_quiet_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    tx_en && tx_en_q |=> !tx_permit);
  assert_late_clears_count_R10: assert property (@(posedge clk) disable iff (rst)
    late_col_stb |-> attempts == '0);
  assert_drop_clears_count_R8: assert property (@(posedge clk) disable iff (rst)
    drop_stb |-> attempts == '0);
  assert_late_no_backoff_R10: assert property (@(posedge clk) disable iff (rst)
    late_col_stb |-> state != ST_BACKOFF);
endmodule

// File: tb/sim_hdx_defer_ctrl.sv
`timescale 1ns/1ps
module sim_hdx_defer_ctrl;
  localparam int GAP  = 12;
  localparam int SLOT = 16;
  localparam int LATE = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b1;
  logic tx_en = 1'b0, crs = 1'b0, col = 1'b0;
  logic cfg_drop_excess = 1'b1, cfg_fast_backoff = 1'b0;
  logic tx_permit, retry_stb, drop_stb, late_col_stb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int exp_q[$];
  int last_r;

  always #2.5 clk = ~clk;

  hdx_defer_ctrl #(.GAP_BITS(GAP), .SLOT_BITS(SLOT), .LATE_BITS(LATE)) u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en), .crs(crs), .col(col),
    .cfg_drop_excess(cfg_drop_excess), .cfg_fast_backoff(cfg_fast_backoff),
    .tx_permit(tx_permit), .retry_stb(retry_stb), .drop_stb(drop_stb),
    .late_col_stb(late_col_stb)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: strobe codes 1=retry 2=drop 4=late
  always @(negedge clk) begin
    if (!rst && !done) begin
      int code;
      code = {29'd0, late_col_stb, drop_stb, retry_stb};
      if (code != 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R12 unexpected strobe", code, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(code == e, "R12 strobe kind", code, e);
        end
      end
    end
  end

  task automatic wait_permit(output int d);
    d = 0;
    do begin @(negedge clk); d++; end while (!tx_permit && d < 40000);
  endtask

  task automatic send_ok(int len, output int d);
    int early;
    early = 0;
    @(negedge clk); tx_en = 1'b1; crs = 1'b1;
    d = 0;
    for (int i = 1; i < 40000; i++) begin
      @(negedge clk);
      if (i < len && tx_permit) early++;
      if (i == len) begin tx_en = 1'b0; crs = 1'b0; end
      if (i >= len && tx_permit) begin d = i; break; end
    end
    chk(early == 0, "R2 permit low during frame", early, 0);
  endtask

  task automatic col_frame(int col_at, int jam, int code, output int d);
    exp_q.push_back(code);
    @(negedge clk); tx_en = 1'b1; crs = 1'b1;
    for (int i = 1; i <= col_at + jam; i++) begin
      @(negedge clk);
      if (i == col_at) col = 1'b1;
      if (i == col_at + jam) begin tx_en = 1'b0; crs = 1'b0; col = 1'b0; end
    end
    wait_permit(d);
  endtask

  task automatic check_bo(int d, int n, bit fast, string tag);
    int cap, k, maxr, e;
    bit ok;
    cap = fast ? 3 : 10;
    k = (n < cap) ? n : cap;
    maxr = (1 << k) - 1;
    ok = 1'b0;
    last_r = -1;
    for (int r = 0; r <= maxr; r++) begin
      e = (GAP + 1 > r * SLOT + 3) ? GAP + 1 : r * SLOT + 3;
      if (d == e) begin ok = 1'b1; last_r = r; end
    end
    chk(ok, tag, d, maxr * SLOT + 3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : driver
    int d, maxr_seen;
    repeat (4) @(negedge clk);
    chk({tx_permit, retry_stb, drop_stb, late_col_stb} == 4'b0, "R1 outputs low in reset",
        {tx_permit, retry_stb, drop_stb, late_col_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_permit == 1'b1, "R1 permit after reset", tx_permit, 1);

    // R2: short and long frames
    send_ok(6, d);
    chk(d == GAP + 2, "R2 short frame gap from tx_en rise", d, GAP + 2);
    send_ok(GAP + 10, d);
    chk(d == GAP + 12, "R2 long frame permit after end", d, GAP + 12);

    // R6: normal backoff, 10 collisions
    cfg_drop_excess = 1'b1; cfg_fast_backoff = 1'b0;
    maxr_seen = 0;
    for (int n = 1; n <= 10; n++) begin
      col_frame(5, 2, 1, d);
      check_bo(d, n, 1'b0, "R6 backoff window");
      if (n >= 5 && last_r > maxr_seen) maxr_seen = last_r;
    end
    chk(maxr_seen > 7, "R6 wide draws in normal mode", maxr_seen, 8);
    // R11: success clears count
    send_ok(6, d);
    col_frame(5, 2, 1, d);
    check_bo(d, 1, 1'b0, "R11 count cleared by good frame");
    send_ok(6, d);

    // R7: aggressive cap
    cfg_fast_backoff = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      col_frame(5, 2, 1, d);
      check_bo(d, n, 1'b1, "R7 aggressive window");
    end
    send_ok(6, d);

    // R8: drop after 16
    for (int n = 1; n <= 15; n++) begin
      col_frame(5, 2, 1, d);
      check_bo(d, n, 1'b1, "R8 retries before limit");
    end
    col_frame(5, 2, 2, d);
    chk(d == GAP + 1, "R8 drop has no backoff", d, GAP + 1);
    col_frame(5, 2, 1, d);
    check_bo(d, 1, 1'b1, "R8 count cleared after drop");
    send_ok(6, d);

    // R9: wrap when drop disabled
    cfg_drop_excess = 1'b0;
    for (int n = 1; n <= 16; n++) begin
      col_frame(5, 2, 1, d);
      check_bo(d, n, 1'b1, "R9 retries through limit");
    end
    cfg_fast_backoff = 1'b0;
    col_frame(5, 2, 1, d);
    check_bo(d, 1, 1'b0, "R9 wrapped count n=1");
    col_frame(5, 2, 1, d);
    check_bo(d, 2, 1'b0, "R9 wrapped count n=2");
    send_ok(6, d);
    cfg_drop_excess = 1'b1;

    // R10: late collision boundary; R5: gap from carrier end
    col_frame(LATE, 2, 1, d);
    check_bo(d, 1, 1'b0, "R10 one tick before threshold retries");
    col_frame(5, 2, 1, d);
    check_bo(d, 2, 1'b0, "R10 second collision");
    col_frame(LATE + 1, GAP + 8, 4, d);
    chk(d == GAP + 1, "R10 R5 late drop, gap from carrier end", d, GAP + 1);
    col_frame(5, 2, 1, d);
    check_bo(d, 1, 1'b0, "R10 count cleared by late collision");
    send_ok(6, d);

    // R3: ticks gate the gap
    @(negedge clk); bit_tick = 1'b0;
    begin
      int hi;
      hi = 0;
      tx_en = 1'b1; crs = 1'b1;
      repeat (6) @(negedge clk);
      tx_en = 1'b0; crs = 1'b0;
      for (int i = 0; i < 3 * GAP; i++) begin
        @(negedge clk);
        if (tx_permit) hi++;
      end
      chk(hi == 0, "R3 no permit without ticks", hi, 0);
    end
    bit_tick = 1'b1;
    wait_permit(d);
    chk(d == GAP + 1, "R3 gap resumes with ticks", d, GAP + 1);

    // R4: remote carrier
    begin
      int hi;
      hi = 0;
      @(negedge clk); crs = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (i >= 1 && tx_permit) hi++;
      end
      chk(hi == 0, "R4 permit low under carrier", hi, 0);
      crs = 1'b0;
      wait_permit(d);
      chk(d == GAP + 1, "R4 gap from carrier end", d, GAP + 1);
    end

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all expected strobes seen", exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule